// File: doc/BRIEF.md
# Single-Wire Host Bus Controller

This block is the host side of a half-duplex, byte-wide bus that runs over one open-drain wire, as battery fuel gauges use. Software loads a byte into the transmit register and then writes the control register to start one of three operations. A transmit shifts the byte out least significant bit first. A receive collects a byte that the slave clocks back. A break sends a long low pulse that returns the slave to a known state.

Every operation ends by setting one flag in an interrupt status register. The controller's start and break bits then return to zero by themselves. Software either polls the registers or waits on the `irq` pin. Reading the status register clears its flags. A soft reset, started from the system configuration register, returns every register to its reset value over a few cycles, and a status bit reports when it has finished.

The register port is a plain single-cycle interface. It has no back-pressure: a write is taken on the edge where `reg_wr` is high, and read data appears on `reg_rdata` in the cycle after `reg_rd`. All bus durations are parameters in clock cycles: `BIT_CYC` bit slot, `ONE_LOW` and `ZERO_LOW` pulse lengths, `BRK_LOW` and `BRK_REC` break timing, `RX_TMO` receive wait, `RX_SAMPLE` sample delay and `RST_CYC` soft-reset length.

Top module: `sline_host`

## Requirements
- R1: `reg_idx` selects a register by word index: 0 revision (reads `{REV_MAJOR, REV_MINOR}` as two nibbles), 1 transmit byte, 2 received byte, 3 control, 4 interrupt status, 5 system configuration, 6 system status. After a hardware reset all of them read 0, except the revision register and system status, which reads 1.
- R2: A transmit sends the byte LSB first. Each bit is a low drive of `ONE_LOW` cycles for a 1 or `ZERO_LOW` cycles for a 0, followed by release for the rest of a `BIT_CYC` slot. The first low cycle starts on the clock edge that accepts the control write.
- R3: Control bit 4 (start) is written to 1 to begin an operation; bit 1 selects the direction (0 transmit, 1 receive). At the end of a transmit, status bit 2 is set and the start bit reads 0. Only one status flag is raised per completion.
- R4: A receive waits for a falling edge from the slave. It samples the line `RX_SAMPLE` cycles after each synchronised falling edge (low gives 0, high gives 1) and assembles eight bits LSB first. It then sets status bit 1, loads the byte into the received-byte register and clears the start bit.
- R5: If `RX_TMO` cycles pass while a receive is waiting for a falling edge, the receive ends: status bit 0 is set, the start bit clears and the received-byte register keeps its old value.
- R6: Writing control bits 2 (break) and 4 together drives the line low for `BRK_LOW` cycles, then releases it for `BRK_REC` cycles. It then sets status bit 0 and clears both bit 2 and bit 4.
- R7: While control bit 6 (interrupt enable) is 1, a read of the status register returns the flags and clears them. While bit 6 is 0, reads leave the flags unchanged.
- R8: If an operation ends while control bit 6 is 0, no status flag is set and the start and break bits stay at 1.
- R9: `irq` is high exactly when control bit 6 is 1 and at least one status flag is set.
- R10: While the start bit reads 1, writes to the transmit and control registers have no effect.
- R11: Writing system configuration bit 1 starts a soft reset. For `RST_CYC` cycles, system status bit 0 reads 0 and register writes are ignored. Every register, including configuration bit 0 (stored auto-idle enable), returns to its reset value.
- R12: `line_drive_low` is asserted only while a transmit or break is driving a low phase. It stays low during a receive and when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request |
| line_drive_low | output | 1 | Pull the bus wire low when 1 (open-drain enable) |
| line_sense | input | 1 | Level of the bus wire |

## Verification
On every cycle, the assertions check the following:
- the interrupt pin is gated by the enable bit;
- the line is driven only while the engine is busy;
- a completion raises at most one flag;
- the start bit clears after a completion when interrupts are enabled and holds when they are disabled;
- an enabled status read empties the flags;
- nothing drives the line during a soft reset.

Other behaviour only the bench's scenarios can show. This covers the exact bit-slot waveform for each byte value, the byte assembled from a responding slave, the receive timeout, ignored writes while busy, and the register contents after a soft reset.

// File: rtl/sline_pkg.sv
package sline_pkg;
  localparam int REG_W = 8;

  localparam logic [2:0] IDX_REV    = 3'd0;
  localparam logic [2:0] IDX_TX     = 3'd1;
  localparam logic [2:0] IDX_RX     = 3'd2;
  localparam logic [2:0] IDX_CTL    = 3'd3;
  localparam logic [2:0] IDX_STAT   = 3'd4;
  localparam logic [2:0] IDX_CFG    = 3'd5;
  localparam logic [2:0] IDX_SYSST  = 3'd6;

  localparam int CTL_MODE = 0;
  localparam int CTL_DIR  = 1;
  localparam int CTL_BRK  = 2;
  localparam int CTL_GO   = 4;
  localparam int CTL_CLK  = 5;
  localparam int CTL_IE   = 6;

  localparam int ST_TMO = 0;
  localparam int ST_RXC = 1;
  localparam int ST_TXC = 2;

  localparam int CFG_IDLE = 0;
  localparam int CFG_SRST = 1;

  typedef enum logic [1:0] {OP_TX, OP_RX, OP_BRK} op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_TXL, S_TXH, S_BRKL, S_BRKH, S_RXW, S_RXS
  } eng_st_e;
endpackage

// File: rtl/sline_sync.sv
module sline_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/sline_engine.sv
module sline_engine
  import sline_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BIT_CYC   = 20,
  parameter int ONE_LOW   = 4,
  parameter int ZERO_LOW  = 12,
  parameter int BRK_LOW   = 40,
  parameter int BRK_REC   = 10,
  parameter int RX_TMO    = 64,
  parameter int RX_SAMPLE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  op_e               op,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              line_lvl,
  output logic              busy,
  output logic              drive_low,
  output logic [2:0]        done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int CW = $clog2(BIT_CYC + BRK_LOW + BRK_REC + RX_TMO + RX_SAMPLE + 1);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST     = BW'(DATA_W - 1);
  localparam logic [CW-1:0] BRKL_END = CW'(BRK_LOW - 1);
  localparam logic [CW-1:0] BRKH_END = CW'(BRK_REC - 1);
  localparam logic [CW-1:0] TMO_END  = CW'(RX_TMO - 1);
  localparam logic [CW-1:0] SMP_END  = CW'(RX_SAMPLE - 1);

  eng_st_e           st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] shreg;
  logic              prev;
  logic              fell;
  logic [CW-1:0]     lo_len, lo_end, hi_end;

  assign fell    = prev & ~line_lvl;
  assign lo_len  = shreg[0] ? CW'(ONE_LOW) : CW'(ZERO_LOW);
  assign lo_end  = lo_len - 1'b1;
  assign hi_end  = CW'(BIT_CYC) - lo_len - 1'b1;
  assign rx_word = {line_lvl, shreg[DATA_W-1:1]};
  assign busy    = (st != S_IDLE);

  always_comb begin
    done = '0;
    done[ST_TXC] = (st == S_TXH) && (cnt == hi_end) && (bitn == LAST);
    done[ST_RXC] = (st == S_RXS) && (cnt == SMP_END) && (bitn == LAST);
    done[ST_TMO] = ((st == S_BRKH) && (cnt == BRKH_END)) ||
                   ((st == S_RXW) && !fell && (cnt == TMO_END));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      drive_low <= 1'b0;
      prev      <= 1'b1;
    end else begin
      prev <= line_lvl;
      if (clr) begin
        st        <= S_IDLE;
        cnt       <= '0;
        bitn      <= '0;
        drive_low <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            cnt  <= '0;
            bitn <= '0;
            case (op)
              OP_TX: begin
                st        <= S_TXL;
                drive_low <= 1'b1;
                shreg     <= tx_byte;
              end
              OP_BRK: begin
                st        <= S_BRKL;
                drive_low <= 1'b1;
              end
              default: begin
                st        <= S_RXW;
                drive_low <= 1'b0;
              end
            endcase
          end
          S_TXL: if (cnt == lo_end) begin
            st        <= S_TXH;
            drive_low <= 1'b0;
            cnt       <= '0;
          end else cnt <= cnt + 1'b1;
          S_TXH: if (cnt == hi_end) begin
            cnt <= '0;
            if (bitn == LAST) st <= S_IDLE;
            else begin
              bitn      <= bitn + 1'b1;
              shreg     <= shreg >> 1;
              st        <= S_TXL;
              drive_low <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
          S_BRKL: if (cnt == BRKL_END) begin
            st        <= S_BRKH;
            drive_low <= 1'b0;
            cnt       <= '0;
          end else cnt <= cnt + 1'b1;
          S_BRKH: if (cnt == BRKH_END) st <= S_IDLE;
                  else cnt <= cnt + 1'b1;
          S_RXW: if (fell) begin
            st  <= S_RXS;
            cnt <= '0;
          end else if (cnt == TMO_END) st <= S_IDLE;
          else cnt <= cnt + 1'b1;
          S_RXS: if (cnt == SMP_END) begin
            shreg <= rx_word;
            cnt   <= '0;
            if (bitn == LAST) st <= S_IDLE;
            else begin
              bitn <= bitn + 1'b1;
              st   <= S_RXW;
            end
          end else cnt <= cnt + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sline_regs.sv
module sline_regs
  import sline_pkg::*;
#(
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1,
  parameter int RST_CYC   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       reg_idx,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [2:0]       eng_done,
  input  logic [REG_W-1:0] eng_rx,
  output logic             eng_start,
  output op_e              eng_op,
  output logic [REG_W-1:0] tx_byte,
  output logic             eng_clr,
  output logic             irq,
  output logic             ctl_go,
  output logic             ctl_ie,
  output logic [2:0]       stat_flags,
  output logic             srst_act
);
  localparam int CNT_W = $clog2(RST_CYC + 1);
  localparam logic [REG_W-1:0] REV_VAL = {4'(REV_MAJOR), 4'(REV_MINOR)};

  logic [CNT_W-1:0] srst_cnt;
  logic [REG_W-1:0] rx_q;
  logic ctl_mode, ctl_dir, ctl_brk, ctl_clk, idle_en;
  logic wr_tx, wr_ctl, wr_cfg, rd_stat, srst_req, accept_ctl, fin_any;

  assign srst_act   = (srst_cnt != '0);
  assign wr_tx      = reg_wr && (reg_idx == IDX_TX)  && !srst_act;
  assign wr_ctl     = reg_wr && (reg_idx == IDX_CTL) && !srst_act;
  assign wr_cfg     = reg_wr && (reg_idx == IDX_CFG) && !srst_act;
  assign rd_stat    = reg_rd && (reg_idx == IDX_STAT);
  assign srst_req   = wr_cfg && reg_wdata[CFG_SRST];
  assign eng_clr    = srst_req || srst_act;
  assign accept_ctl = wr_ctl && !ctl_go;
  assign eng_start  = accept_ctl && reg_wdata[CTL_GO];
  assign eng_op     = reg_wdata[CTL_BRK] ? OP_BRK : (reg_wdata[CTL_DIR] ? OP_RX : OP_TX);
  assign fin_any    = |eng_done;
  assign irq        = ctl_ie && (|stat_flags);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_cnt   <= '0;
      tx_byte    <= '0;
      rx_q       <= '0;
      stat_flags <= '0;
      idle_en    <= 1'b0;
      {ctl_mode, ctl_dir, ctl_brk, ctl_go, ctl_clk, ctl_ie} <= '0;
    end else if (eng_clr) begin
      srst_cnt   <= srst_req ? CNT_W'(RST_CYC) : srst_cnt - 1'b1;
      tx_byte    <= '0;
      rx_q       <= '0;
      stat_flags <= '0;
      idle_en    <= 1'b0;
      {ctl_mode, ctl_dir, ctl_brk, ctl_go, ctl_clk, ctl_ie} <= '0;
    end else begin
      if (wr_tx && !ctl_go) tx_byte <= reg_wdata;
      if (accept_ctl) begin
        ctl_mode <= reg_wdata[CTL_MODE];
        ctl_dir  <= reg_wdata[CTL_DIR];
        ctl_brk  <= reg_wdata[CTL_BRK];
        ctl_go   <= reg_wdata[CTL_GO];
        ctl_clk  <= reg_wdata[CTL_CLK];
        ctl_ie   <= reg_wdata[CTL_IE];
      end else if (fin_any && ctl_ie) begin
        ctl_go  <= 1'b0;
        ctl_brk <= 1'b0;
      end
      if (wr_cfg) idle_en <= reg_wdata[CFG_IDLE];
      if (eng_done[ST_RXC]) rx_q <= eng_rx;
      stat_flags <= ((rd_stat && ctl_ie) ? 3'b000 : stat_flags) |
                    (ctl_ie ? eng_done : 3'b000);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_idx)
        IDX_REV:   reg_rdata <= REV_VAL;
        IDX_TX:    reg_rdata <= tx_byte;
        IDX_RX:    reg_rdata <= rx_q;
        IDX_CTL:   reg_rdata <= {1'b0, ctl_ie, ctl_clk, ctl_go, 1'b0, ctl_brk, ctl_dir, ctl_mode};
        IDX_STAT:  reg_rdata <= {5'b0, stat_flags};
        IDX_CFG:   reg_rdata <= {7'b0, idle_en};
        IDX_SYSST: reg_rdata <= {7'b0, !srst_act};
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sline_host.sv
module sline_host
  import sline_pkg::*;
#(
  parameter int REV_MAJOR   = 2,
  parameter int REV_MINOR   = 1,
  parameter int BIT_CYC     = 20,
  parameter int ONE_LOW     = 4,
  parameter int ZERO_LOW    = 12,
  parameter int BRK_LOW     = 40,
  parameter int BRK_REC     = 10,
  parameter int RX_TMO      = 64,
  parameter int RX_SAMPLE   = 8,
  parameter int RST_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_idx,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       line_drive_low,
  input  logic       line_sense
);
  logic             line_lvl, eng_start, eng_clr, eng_busy;
  logic             ctl_go, ctl_ie, srst_act;
  logic [2:0]       eng_done, stat_flags;
  logic [REG_W-1:0] eng_rx, tx_byte;
  op_e              eng_op;

  sline_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_sense), .q(line_lvl)
  );

  sline_regs #(.REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR), .RST_CYC(RST_CYC)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_done(eng_done), .eng_rx(eng_rx),
    .eng_start(eng_start), .eng_op(eng_op), .tx_byte(tx_byte), .eng_clr(eng_clr),
    .irq(irq), .ctl_go(ctl_go), .ctl_ie(ctl_ie), .stat_flags(stat_flags),
    .srst_act(srst_act)
  );

  sline_engine #(
    .DATA_W(REG_W), .BIT_CYC(BIT_CYC), .ONE_LOW(ONE_LOW), .ZERO_LOW(ZERO_LOW),
    .BRK_LOW(BRK_LOW), .BRK_REC(BRK_REC), .RX_TMO(RX_TMO), .RX_SAMPLE(RX_SAMPLE)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .clr(eng_clr), .start(eng_start), .op(eng_op),
    .tx_byte(tx_byte), .line_lvl(line_lvl), .busy(eng_busy),
    .drive_low(line_drive_low), .done(eng_done), .rx_word(eng_rx)
  );
endmodule

// File: rtl/sline_host_chk.sv
module sline_host_chk
  import sline_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       reg_rd,
  input logic [2:0] reg_idx,
  input logic       irq,
  input logic       drv,
  input logic       eng_busy,
  input logic       go,
  input logic       ie,
  input logic [2:0] fin,
  input logic       srst,
  input logic [2:0] stat
);
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie && stat != 3'b000));

  assert_line_only_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> eng_busy);

  assert_one_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fin));

  assert_go_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fin != 3'b000 && ie) |=> !go);

  assert_go_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin != 3'b000 && !ie) |=> (go || srst));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_idx == IDX_STAT && ie && fin == 3'b000) |=> (stat == 3'b000));

  assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    srst |-> (!drv && !eng_busy));
endmodule

bind sline_host sline_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_idx(reg_idx), .irq(irq),
  .drv(line_drive_low), .eng_busy(eng_busy), .go(ctl_go), .ie(ctl_ie),
  .fin(eng_done), .srst(srst_act), .stat(stat_flags)
);

// File: tb/tb_sline_host.sv
module tb_sline_host;
  localparam int BIT_CYC = 20, ONE_LOW = 4, ZERO_LOW = 12, BRK_LOW = 40, BRK_REC = 10;
  localparam int RX_TMO = 64, RX_SAMPLE = 8, RST_CYC = 4;
  localparam logic [2:0] I_REV = 0, I_TX = 1, I_RX = 2, I_CTL = 3, I_STAT = 4, I_CFG = 5, I_SYSST = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [2:0] reg_idx = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, line_drive_low, line_sense;
  logic       slave_lvl = 1'b1;

  assign line_sense = ~line_drive_low & slave_lvl;

  sline_host #(
    .REV_MAJOR(2), .REV_MINOR(1), .BIT_CYC(BIT_CYC), .ONE_LOW(ONE_LOW),
    .ZERO_LOW(ZERO_LOW), .BRK_LOW(BRK_LOW), .BRK_REC(BRK_REC), .RX_TMO(RX_TMO),
    .RX_SAMPLE(RX_SAMPLE), .RST_CYC(RST_CYC), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .line_drive_low(line_drive_low), .line_sense(line_sense)
  );

  int n_vec = 0, n_bad = 0;
  bit drv_q[$];
  bit slv_q[$];

  // behavioural reference state
  bit       m_ie = 0, m_go = 0, m_active = 0, m_known = 1;
  bit [2:0] m_flags = 0, m_kind = 0;
  bit [7:0] m_tx = 0;
  string    m_req = "R12";
  bit       p_ctl_v = 0, p_tx_v = 0, p_srst = 0, p_rdclr = 0;
  bit [7:0] p_ctl = 0, p_tx = 0;

  task automatic check(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_tx(bit [7:0] b);
    for (int i = 0; i < 8; i++) begin
      int lo;
      lo = b[i] ? ONE_LOW : ZERO_LOW;
      for (int k = 0; k < BIT_CYC; k++) drv_q.push_back(k < lo);
    end
  endtask

  task automatic push_slave(bit [7:0] b);
    for (int k = 0; k < 5; k++) slv_q.push_back(1'b1);
    for (int i = 0; i < 8; i++) begin
      int lo;
      lo = b[i] ? 3 : 13;
      for (int k = 0; k < BIT_CYC; k++) slv_q.push_back(!(k < lo));
    end
  endtask

  task automatic tick();
    bit exp_d;
    @(posedge clk);
    @(negedge clk);
    if (p_srst) begin
      p_srst = 0; m_go = 0; m_ie = 0; m_flags = 0; m_tx = 0; m_active = 0;
      m_known = 1; drv_q.delete();
    end
    if (p_tx_v) begin
      p_tx_v = 0;
      if (!m_go) m_tx = p_tx;
    end
    if (p_rdclr) begin
      p_rdclr = 0;
      if (m_ie) m_flags = 0;
    end
    if (p_ctl_v) begin
      p_ctl_v = 0;
      if (!m_go) begin
        m_ie = p_ctl[6];
        m_go = p_ctl[4];
        if (p_ctl[4]) begin
          if (p_ctl[2]) begin
            for (int k = 0; k < BRK_LOW + BRK_REC; k++) drv_q.push_back(k < BRK_LOW);
            m_kind = 3'b001; m_active = 1; m_req = "R6";
          end else if (p_ctl[1]) begin
            m_known = 0; m_req = "R12";
          end else begin
            push_tx(m_tx);
            m_kind = 3'b100; m_active = 1; m_req = "R2";
          end
        end
      end
    end
    slave_lvl = (slv_q.size() > 0) ? slv_q.pop_front() : 1'b1;
    if (drv_q.size() > 0) exp_d = drv_q.pop_front();
    else begin
      exp_d = 0;
      if (m_active) begin
        m_active = 0;
        if (m_ie) begin m_flags |= m_kind; m_go = 0; end
        m_req = "R12";
      end
    end
    check(m_req, "line_drive_low", int'(line_drive_low), int'(exp_d));
    if (m_known) check("R9", "irq", int'(irq), int'(m_ie && m_flags != 0));
  endtask

  task automatic wr(logic [2:0] idx, logic [7:0] v);
    reg_idx = idx; reg_wdata = v; reg_wr = 1'b1;
    if (idx == I_CTL) begin p_ctl_v = 1; p_ctl = v; end
    if (idx == I_TX)  begin p_tx_v = 1;  p_tx = v;  end
    if (idx == I_CFG && v[1]) p_srst = 1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic exp_rd(logic [2:0] idx, logic [7:0] exp, string req);
    reg_idx = idx; reg_rd = 1'b1;
    if (idx == I_STAT) p_rdclr = 1;
    tick();
    check(req, $sformatf("reg[%0d]", idx), int'(reg_rdata), int'(exp));
    reg_rd = 1'b0;
  endtask

  task automatic wait_ops();
    while (drv_q.size() > 0) tick();
    tick(); tick();
  endtask

  task automatic settle(int n, bit [2:0] kind);
    repeat (n) tick();
    if (m_ie) begin m_flags |= kind; m_go = 0; end
    m_known = 1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset values and map
    exp_rd(I_REV, 8'h21, "R1");
    exp_rd(I_CTL, 8'h00, "R1");
    exp_rd(I_STAT, 8'h00, "R1");
    exp_rd(I_SYSST, 8'h01, "R1");
    exp_rd(I_TX, 8'h00, "R1");
    exp_rd(I_RX, 8'h00, "R1");
    // R2 R3 transmit
    wr(I_CTL, 8'h60);
    wr(I_TX, 8'hA5);
    wr(I_CTL, 8'h70);
    wait_ops();
    check("R9", "irq after tx", int'(irq), 1);
    exp_rd(I_CTL, 8'h60, "R3");
    exp_rd(I_STAT, 8'h04, "R3");
    check("R7", "irq after clearing read", int'(irq), 0);
    exp_rd(I_STAT, 8'h00, "R7");
    // R10 writes ignored while busy
    wr(I_TX, 8'h3C);
    wr(I_CTL, 8'h70);
    wr(I_TX, 8'hFF);
    wr(I_CTL, 8'h00);
    wait_ops();
    exp_rd(I_TX, 8'h3C, "R10");
    exp_rd(I_CTL, 8'h60, "R10");
    exp_rd(I_STAT, 8'h04, "R3");
    // R6 break
    wr(I_CTL, 8'h74);
    wait_ops();
    exp_rd(I_CTL, 8'h60, "R6");
    exp_rd(I_STAT, 8'h01, "R6");
    // R4 receive, two byte patterns
    push_slave(8'h96);
    wr(I_CTL, 8'h72);
    settle(200, 3'b010);
    exp_rd(I_RX, 8'h96, "R4");
    exp_rd(I_CTL, 8'h62, "R4");
    exp_rd(I_STAT, 8'h02, "R4");
    push_slave(8'h0F);
    wr(I_CTL, 8'h72);
    settle(200, 3'b010);
    exp_rd(I_RX, 8'h0F, "R4");
    exp_rd(I_STAT, 8'h02, "R4");
    // R5 receive timeout, no slave
    wr(I_CTL, 8'h72);
    settle(RX_TMO + 30, 3'b001);
    exp_rd(I_CTL, 8'h62, "R5");
    exp_rd(I_RX, 8'h0F, "R5");
    // R7 flags kept while interrupts disabled
    wr(I_CTL, 8'h20);
    check("R9", "irq gated off", int'(irq), 0);
    exp_rd(I_STAT, 8'h01, "R7");
    exp_rd(I_STAT, 8'h01, "R7");
    // R8 completion with interrupts disabled
    wr(I_TX, 8'hC3);
    wr(I_CTL, 8'h30);
    wait_ops();
    exp_rd(I_CTL, 8'h30, "R8");
    exp_rd(I_STAT, 8'h01, "R8");
    wr(I_TX, 8'h11);
    exp_rd(I_TX, 8'hC3, "R10");
    // R11 soft reset
    wr(I_CFG, 8'h03);
    exp_rd(I_SYSST, 8'h00, "R11");
    repeat (RST_CYC + 4) tick();
    exp_rd(I_SYSST, 8'h01, "R11");
    exp_rd(I_CTL, 8'h00, "R11");
    exp_rd(I_STAT, 8'h00, "R11");
    exp_rd(I_TX, 8'h00, "R11");
    exp_rd(I_RX, 8'h00, "R11");
    exp_rd(I_CFG, 8'h00, "R11");
    wr(I_CFG, 8'h01);
    exp_rd(I_CFG, 8'h01, "R11");
    // R2 all-ones byte after reset
    wr(I_CTL, 8'h60);
    wr(I_TX, 8'hFF);
    wr(I_CTL, 8'h70);
    wait_ops();
    exp_rd(I_STAT, 8'h04, "R2");
    repeat (4) tick();
    finish_run();
  end
endmodule